// File: doc/BRIEF.md
# Variable-Format Instruction Operand Prefetcher

This block sits between a 16-bit instruction memory read port and an instruction decoder. It keeps a small byte queue of up to four instruction bytes filled ahead of execution. The decoder asks for the next operand in one of four formats and receives a 16-bit value. The matching number of bytes is then removed from the front of the queue.

Reads go out one halfword at a time, and their data returns one cycle later. When the decoder jumps, it loads a new byte address. That empties the queue and restarts fetching from the halfword that holds the address. If the address is odd, the lower byte of the first returned halfword is dropped.

The consumer holds `req_valid` and `req_fmt` steady. The block raises `out_valid` only when the queue holds enough bytes for that format. A transfer happens in a cycle where both `out_valid` and `out_ready` are high.

Top module: `opnd_prefetch`

## Requirements
- R1: After reset no memory read is issued and `out_valid` stays low, even with a request pending, until a fetch address is loaded.
- R2: In a cycle with `flush_valid` high, no read is issued and `out_valid` is low. In the next cycle the queue is empty and a read is issued at halfword address `flush_addr[15:1]`.
- R3: After an odd fetch address, the first operand byte delivered is the byte at that odd address. The lower byte of the first halfword is discarded.
- R4: Read data arrives on `mem_rd_data` one cycle after `mem_rd_en`, with the even-address byte in bits 7:0. Reads go to consecutive halfword addresses. A read is issued only while the held bytes plus the bytes arriving in that cycle number at most two, so the queue never holds more than four bytes.
- R5: Format code 0 (signed byte) returns the next byte sign-extended to 16 bits and consumes one byte.
- R6: Format code 1 (unsigned byte) returns the next byte zero-extended and consumes one byte.
- R7: Format code 2 (word) returns two bytes, least significant first, from any byte offset, and consumes two bytes.
- R8: Format code 3 (compressed) whose first byte has bit 7 clear returns that byte (0..127) and consumes one byte. One held byte is enough to answer it.
- R9: Format code 3 whose first byte has bit 7 set returns ((first & 0x7F) << 8) | second and consumes two bytes. The result is always below 32768.
- R10: `out_valid` is high only while `req_valid` is high and enough bytes are held. Bytes are consumed only in a cycle with `out_valid` and `out_ready` both high.
- R11: Across any mix of formats, operands cover the byte stream in address order, with no byte skipped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_valid | input | 1 | Load a new fetch byte address |
| flush_addr | input | 16 | New fetch byte address |
| mem_rd_en | output | 1 | Instruction memory read strobe |
| mem_rd_addr | output | 15 | Halfword address of the read |
| mem_rd_data | input | 16 | Read data, one cycle after the strobe |
| req_valid | input | 1 | Operand request pending |
| req_fmt | input | 2 | 0 signed byte, 1 unsigned byte, 2 word, 3 compressed |
| out_valid | output | 1 | Operand available for the current request |
| out_ready | input | 1 | Consumer accepts the operand |
| out_data | output | 16 | Operand value |

## Verification
The operand path is combinational from the queue head. A request's value appears in the same cycle as the request once enough bytes are held, and the consumed bytes leave at the next rising edge.

After a flush edge, the first read strobe is due one cycle later. A second read at the following halfword comes one cycle after that, and then the strobe drops for a cycle while the queue fills. The bench samples all of these a few nanoseconds after the falling edge, in exactly those cycles.

The scoreboard's monitor compares a result only in a cycle where the handshake completes. Stalls and partly filled queues therefore move when a value is checked, never what value is expected.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        FMT_SBYTE = 2'd0,
        FMT_UBYTE = 2'd1,
        FMT_WORD  = 2'd2,
        FMT_BIG   = 2'd3
    } opnd_fmt_e;

    // Decoded answer for the current request
    typedef struct packed {
        logic              ok;
        logic [HALF_W-1:0] value;
        logic [1:0]        used;
    } opnd_res_t;

    // Tag of a read whose data returns in the current cycle
    typedef struct packed {
        logic vld;
        logic drop_low;
    } rd_tag_t;

    function automatic opnd_res_t decode_operand(
        input opnd_fmt_e          fmt,
        input logic [BYTE_W-1:0]  b0,
        input logic [BYTE_W-1:0]  b1,
        input logic               have1,
        input logic               have2
    );
        opnd_res_t r;
        r = '0;
        unique case (fmt)
            FMT_SBYTE: begin
                r.ok    = have1;
                r.value = {{BYTE_W{b0[BYTE_W-1]}}, b0};
                r.used  = 2'd1;
            end
            FMT_UBYTE: begin
                r.ok    = have1;
                r.value = {{BYTE_W{1'b0}}, b0};
                r.used  = 2'd1;
            end
            FMT_WORD: begin
                r.ok    = have2;
                r.value = {b1, b0};
                r.used  = 2'd2;
            end
            FMT_BIG: begin
                if (!b0[BYTE_W-1]) begin
                    r.ok    = have1;
                    r.value = {{BYTE_W{1'b0}}, b0};
                    r.used  = 2'd1;
                end else begin
                    r.ok    = have2;
                    r.value = {1'b0, b0[BYTE_W-2:0], b1};
                    r.used  = 2'd2;
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [1:0] arrive_bytes(input rd_tag_t t);
        if (!t.vld)      return 2'd0;
        if (t.drop_low)  return 2'd1;
        return 2'd2;
    endfunction

endpackage

// File: rtl/opnd_decode.sv
module opnd_decode
    import opnd_pkg::*;
#(
    parameter  int BUF_BYTES = 4,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic [BYTE_W-1:0] head0,
    input  logic [BYTE_W-1:0] head1,
    input  logic [CNT_W-1:0]  fill,
    input  opnd_fmt_e         fmt,
    output opnd_res_t         res
);
    logic have1;
    logic have2;

    assign have1 = (fill >= CNT_W'(1));
    assign have2 = (fill >= CNT_W'(2));

    always_comb begin
        res = decode_operand(fmt, head0, head1, have1, have2);
    end

endmodule

// File: rtl/opnd_buffer.sv
module opnd_buffer
    import opnd_pkg::*;
#(
    parameter  int BUF_BYTES = 4,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [1:0]        take_n,
    input  logic [1:0]        add_n,
    input  logic [HALF_W-1:0] add_data,
    output logic [BYTE_W-1:0] head0,
    output logic [BYTE_W-1:0] head1,
    output logic [CNT_W-1:0]  fill
);
    logic [BYTE_W-1:0] lane_q [BUF_BYTES];
    logic [BYTE_W-1:0] lane_d [BUF_BYTES];
    logic [BYTE_W-1:0] ext    [BUF_BYTES + 2];
    logic [CNT_W-1:0]  fill_q;
    logic [CNT_W-1:0]  keep;

    assign keep  = fill_q - CNT_W'(take_n);
    assign fill  = fill_q;
    assign head0 = lane_q[0];
    assign head1 = lane_q[1];

    // Zero-padded view so a shifted index never leaves the array
    for (genvar e = 0; e < BUF_BYTES + 2; e++) begin : g_ext
        if (e < BUF_BYTES) begin : g_real
            assign ext[e] = lane_q[e];
        end else begin : g_pad
            assign ext[e] = '0;
        end
    end

    // Each lane: shift down by the consumed count, then append new bytes
    for (genvar i = 0; i < BUF_BYTES; i++) begin : g_lane
        always_comb begin
            int slot;
            slot = i - int'(keep);
            if (i < int'(keep)) begin
                lane_d[i] = ext[i + int'(take_n)];
            end else if (slot == 0 && add_n != 2'd0) begin
                lane_d[i] = add_data[BYTE_W-1:0];
            end else if (slot == 1 && add_n == 2'd2) begin
                lane_d[i] = add_data[HALF_W-1:BYTE_W];
            end else begin
                lane_d[i] = lane_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            fill_q <= '0;
            for (int k = 0; k < BUF_BYTES; k++) lane_q[k] <= '0;
        end else begin
            fill_q <= keep + CNT_W'(add_n);
            for (int k = 0; k < BUF_BYTES; k++) lane_q[k] <= lane_d[k];
        end
    end

endmodule

// File: rtl/opnd_refill.sv
module opnd_refill
    import opnd_pkg::*;
#(
    parameter  int ADDR_W = 16,
    localparam int HW_W   = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_valid,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              room,
    output logic              rd_en,
    output logic [HW_W-1:0]   rd_addr,
    output rd_tag_t           arrive
);
    logic            armed;
    logic            odd_q;
    logic [HW_W-1:0] ptr_q;
    rd_tag_t         tag_q;

    assign rd_en   = armed & ~flush_valid & room;
    assign rd_addr = ptr_q;
    assign arrive  = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            odd_q <= 1'b0;
            ptr_q <= '0;
            tag_q <= '0;
        end else if (flush_valid) begin
            armed <= 1'b1;
            odd_q <= flush_addr[0];
            ptr_q <= flush_addr[ADDR_W-1:1];
            tag_q <= '0;
        end else begin
            tag_q.vld      <= rd_en;
            tag_q.drop_low <= rd_en & odd_q;
            if (rd_en) begin
                ptr_q <= ptr_q + HW_W'(1);
                odd_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/opnd_prefetch.sv
module opnd_prefetch
    import opnd_pkg::*;
#(
    parameter  int ADDR_W    = 16,
    parameter  int BUF_BYTES = 4,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush_valid,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-2:0] mem_rd_addr,
    input  logic [15:0]       mem_rd_data,
    input  logic              req_valid,
    input  logic [1:0]        req_fmt,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_data
);
    rd_tag_t           arrive;
    logic [1:0]        add_n;
    logic [HALF_W-1:0] add_data;
    logic [1:0]        take_n;
    logic [BYTE_W-1:0] head0;
    logic [BYTE_W-1:0] head1;
    logic [CNT_W-1:0]  fill_cnt;
    logic              room;
    opnd_res_t         res;

    assign add_n    = arrive_bytes(arrive);
    assign add_data = arrive.drop_low ? {{BYTE_W{1'b0}}, mem_rd_data[HALF_W-1:BYTE_W]}
                                      : mem_rd_data;

    // Two free slots after the bytes landing this cycle
    assign room = (int'(fill_cnt) + int'(add_n)) <= (BUF_BYTES - 2);

    assign out_valid = req_valid & res.ok & ~flush_valid;
    assign out_data  = res.value;
    assign take_n    = (out_valid & out_ready) ? res.used : 2'd0;

    opnd_refill #(.ADDR_W(ADDR_W)) u_refill (
        .clk         (clk),
        .rst         (rst),
        .flush_valid (flush_valid),
        .flush_addr  (flush_addr),
        .room        (room),
        .rd_en       (mem_rd_en),
        .rd_addr     (mem_rd_addr),
        .arrive      (arrive)
    );

    opnd_buffer #(.BUF_BYTES(BUF_BYTES)) u_buffer (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush_valid),
        .take_n   (take_n),
        .add_n    (add_n),
        .add_data (add_data),
        .head0    (head0),
        .head1    (head1),
        .fill     (fill_cnt)
    );

    opnd_decode #(.BUF_BYTES(BUF_BYTES)) u_decode (
        .head0 (head0),
        .head1 (head1),
        .fill  (fill_cnt),
        .fmt   (opnd_fmt_e'(req_fmt)),
        .res   (res)
    );

endmodule

// File: rtl/opnd_prefetch_chk.sv
module opnd_prefetch_chk #(
    parameter  int ADDR_W    = 16,
    parameter  int BUF_BYTES = 4,
    localparam int CNT_W     = $clog2(BUF_BYTES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_valid,
    input logic [ADDR_W-1:0] flush_addr,
    input logic              mem_rd_en,
    input logic [ADDR_W-2:0] mem_rd_addr,
    input logic              req_valid,
    input logic [1:0]        req_fmt,
    input logic              out_valid,
    input logic [15:0]       out_data,
    input logic [CNT_W-1:0]  fill_cnt
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_rd_en && !out_valid));

    p_no_read_in_flush_r2: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> !mem_rd_en);

    p_flush_empties_r2: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> (fill_cnt == '0 && !out_valid));

    p_flush_first_read_r2: assert property (@(posedge clk) disable iff (rst)
        flush_valid ##1 !flush_valid |->
            (mem_rd_en && mem_rd_addr == $past(flush_addr[ADDR_W-1:1])));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        int'(fill_cnt) <= BUF_BYTES);

    p_sign_extend_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_fmt == 2'd0) |-> (out_data[15:8] == {8{out_data[7]}}));

    p_zero_extend_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_fmt == 2'd1) |-> (out_data[15:8] == 8'h00));

    p_big_range_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && req_fmt == 2'd3) |-> !out_data[15]);

    p_valid_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> req_valid);

endmodule

bind opnd_prefetch opnd_prefetch_chk #(
    .ADDR_W    (ADDR_W),
    .BUF_BYTES (BUF_BYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush_valid (flush_valid),
    .flush_addr  (flush_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .req_valid   (req_valid),
    .req_fmt     (req_fmt),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .fill_cnt    (fill_cnt)
);

// File: tb/test_opnd_prefetch.sv
module test_opnd_prefetch;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_valid = 1'b0;
    logic [15:0] flush_addr = '0;
    logic        mem_rd_en;
    logic [14:0] mem_rd_addr;
    logic [15:0] mem_rd_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_fmt = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    int pos   = 0;
    bit ended = 0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    opnd_prefetch i_opnd_prefetch (
        .clk         (clk),
        .rst         (rst),
        .flush_valid (flush_valid),
        .flush_addr  (flush_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .req_valid   (req_valid),
        .req_fmt     (req_fmt),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_data    (out_data)
    );

    function automatic logic [7:0] mbyte(input int a);
        int h;
        h = a * 29 + 7;
        return 8'(h ^ (a >> 3));
    endfunction

    // Instruction memory: one cycle read latency, even byte low (R4)
    always @(posedge clk) begin
        if (mem_rd_en)
            mem_rd_data <= {mbyte(2 * int'(mem_rd_addr) + 1), mbyte(2 * int'(mem_rd_addr))};
        else
            mem_rd_data <= 16'h0000;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Driver: pushes the expected value, then holds the request until taken
    task automatic fetch_op(input logic [1:0] fmt, input bit stall, input string note);
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [15:0] v;
        int          n;
        string       t;
        @(negedge clk);
        b0 = mbyte(pos);
        b1 = mbyte(pos + 1);
        case (fmt)
            2'd0: begin v = {{8{b0[7]}}, b0}; n = 1; t = "R5"; end
            2'd1: begin v = {8'h00, b0};      n = 1; t = "R6"; end
            2'd2: begin v = {b1, b0};         n = 2; t = "R7"; end
            default: begin
                if (!b0[7]) begin v = {8'h00, b0}; n = 1; t = "R8"; end
                else begin v = {1'b0, b0[6:0], b1}; n = 2; t = "R9"; end
            end
        endcase
        pos += n;
        exp_q.push_back(v);
        tag_q.push_back({t, " R11 ", note});
        req_valid = 1'b1;
        req_fmt   = fmt;
        out_ready = !stall;
        if (stall) begin
            repeat (3) @(negedge clk);
            out_ready = 1'b1;
        end
        forever begin
            #3;
            if (out_valid) begin
                @(posedge clk);
                #1;
                req_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Monitor: compares every completed handshake against the queue
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (req_valid && out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected transfer", out_data, 0);
                end else begin
                    logic [15:0] e;
                    string       tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(out_data === e, tg, out_data, e);
                end
            end
        end
    end

    task automatic do_flush(input logic [15:0] a);
        @(negedge clk);
        flush_valid = 1'b1;
        flush_addr  = a;
        #3;
        chk(!mem_rd_en, "R2 no read in flush cycle", mem_rd_en, 0);
        chk(!out_valid, "R2 no operand in flush cycle", out_valid, 0);
        @(negedge clk);
        flush_valid = 1'b0;
        #3;
        chk(mem_rd_en && mem_rd_addr == a[15:1], "R2 first read address", mem_rd_addr, a[15:1]);
        @(negedge clk);
        #3;
        chk(mem_rd_en && mem_rd_addr == a[15:1] + 15'd1, "R4 second read address",
            mem_rd_addr, a[15:1] + 15'd1);
        @(negedge clk);
        #3;
        chk(!mem_rd_en, "R4 read held back while queue fills", mem_rd_en, 0);
        pos = int'(a);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst       = 1'b0;
        req_valid = 1'b1;
        req_fmt   = 2'd1;
        out_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #3;
            chk(!mem_rd_en, "R1 no read before fetch address", mem_rd_en, 0);
            chk(!out_valid, "R1 no operand before fetch address", out_valid, 0);
            @(negedge clk);
        end
        req_valid = 1'b0;

        do_flush(16'h0010);
        for (int i = 0; i < 40; i++)
            fetch_op(2'((i * 5 + i / 3) % 4), (i % 7) == 3, "even stream");

        do_flush(16'h0123);
        fetch_op(2'd1, 1'b0, "R3 first byte at odd address");
        for (int i = 0; i < 40; i++)
            fetch_op(2'((i * 3 + i / 2) % 4), (i % 9) == 5, "odd stream");

        repeat (6) @(negedge clk);
        #3;
        chk(!out_valid, "R10 no operand without request", out_valid, 0);

        do_flush(16'h7FF7);
        fetch_op(2'd2, 1'b0, "R3 word from odd start");
        for (int i = 0; i < 30; i++)
            fetch_op(2'd3, (i % 5) == 2, "compressed run");
        for (int i = 0; i < 12; i++)
            fetch_op(2'd2, 1'b0, "word run");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R10 every expected operand delivered", exp_q.size(), 0);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

endmodule